// File: doc/BRIEF.md
# Adaptive Cruise Mode Controller

This block is the decision core of a simple adaptive cruise feature. It tracks one of four modes: idle, automatic speed holding, driver override and brake lockout. It moves between them on the enable switch, the brake pedal and the accelerator pedal. When cruise engages, the block latches the vehicle's present 6-bit speed as its target. While it is holding speed automatically, it compares the live speed with that target and asks for more or less throttle.

Braking always wins. It drops the block into a lockout mode that only leads back to idle once the pedal is released, so cruise must be engaged again from scratch. Pressing the accelerator while cruise is active hands speed control to the driver, without cancelling cruise, until the pedal is released.

Top module: `cruise_ctrl_top`

## Requirements
- R1: A synchronous active-low reset, seen at a rising clock edge, forces idle mode and clears the captured target speed. After reset, cruise_on_o, accel_o and decel_o are all 0.
- R2: From idle, cruise engages on the next rising edge only if enable is 1 and brake is 0. Any other input combination leaves the block idle, with all three outputs at 0.
- R3: Engagement also requires a current speed of 50 or less. A speed of 50 engages; a speed of 51 or more keeps the block idle.
- R4: The target speed is loaded from speed_i on the edge that engages cruise. Later speed changes do not alter it.
- R5: In automatic mode, accel_o is 1 when speed_i is below the target and decel_o is 1 when it is above. Both are 0 when the two are equal. Both outputs follow speed_i within the same cycle.
- R6: In automatic mode with the accelerator at 1 and brake at 0, the next edge enters override mode. In override mode cruise_on_o is 1, and accel_o and decel_o are 0.
- R7: In override mode with the accelerator at 0 and brake at 0, the next edge returns to automatic mode.
- R8: In automatic or override mode, brake at 1 enters lockout mode on the next edge, whatever the accelerator input is.
- R9: Lockout mode holds while brake is 1. The first edge with brake at 0 goes to idle, never straight to automatic mode, even if enable is 1.
- R10: cruise_on_o is 1 exactly in automatic and override modes. accel_o and decel_o are 0 in every mode except automatic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Cruise enable switch |
| brake_i | input | 1 | Brake pedal pressed |
| pedal_i | input | 1 | Accelerator pedal pressed |
| speed_i | input | 6 | Current speed, unsigned, 0 to 63 |
| cruise_on_o | output | 1 | Cruise active (automatic or override) |
| accel_o | output | 1 | Request to speed up |
| decel_o | output | 1 | Request to slow down |

## Verification
The assertions assume that the pedal and switch inputs are stable, known levels at each rising edge. They also assume speed_i is a plain unsigned value, so that the limit of 50 and the target comparison have a definite meaning every cycle. The bench changes inputs only one time unit after a rising edge and samples before the next edge. This keeps every input level defined across each edge and avoids races at the edge. Reset is held for several edges before any scenario starts, so no property sees an undefined mode.

// File: rtl/cc_pkg.sv
// Package: shared types and limits for the cruise mode controller.
// Assumes: two mode bits; the encoding is fixed because tests and
// downstream decode rely on it.
package cc_pkg;
    localparam int SPEED_W    = 6;
    localparam int ENGAGE_MAX = 50;

    typedef enum logic [1:0] {
        MODE_IDLE     = 2'b00,
        MODE_AUTO     = 2'b01,
        MODE_OVERRIDE = 2'b10,
        MODE_LOCKOUT  = 2'b11
    } cc_mode_t;
endpackage

// File: rtl/cc_speed_cmp.sv
// Module: cc_speed_cmp
// Compares live speed with the captured target and with the engage limit.
// Assumes: unsigned speeds of SPEED_W bits; purely combinational.
module cc_speed_cmp #(
    parameter int SPEED_W    = 6,
    parameter int ENGAGE_MAX = 50
) (
    input  logic [SPEED_W-1:0] speed_i,
    input  logic [SPEED_W-1:0] target_i,
    output logic               below_o,
    output logic               above_o,
    output logic               in_window_o
);
    localparam logic [SPEED_W-1:0] LIMIT = SPEED_W'(ENGAGE_MAX);

    // Magnitude comparison and engage-window check.
    always_comb begin
        below_o     = speed_i < target_i;
        above_o     = speed_i > target_i;
        in_window_o = speed_i <= LIMIT;
    end
endmodule

// File: rtl/cc_setpoint_reg.sv
// Module: cc_setpoint_reg
// Holds the target speed, loaded on the engaging edge only.
// Assumes: load_i is a single-cycle qualifier from the mode FSM.
module cc_setpoint_reg #(
    parameter int SPEED_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [SPEED_W-1:0] speed_i,
    output logic [SPEED_W-1:0] target_o
);
    // Target register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      target_o <= '0;
        else if (load_i) target_o <= speed_i;
    end
endmodule

// File: rtl/cc_mode_fsm.sv
// Module: cc_mode_fsm
// Four-mode state register and next-mode logic; brake outranks the
// accelerator pedal, and lockout exits only through idle.
// Assumes: inputs synchronous to clk.
module cc_mode_fsm
    import cc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     enable_i,
    input  logic     brake_i,
    input  logic     pedal_i,
    input  logic     in_window_i,
    output cc_mode_t mode_o,
    output logic     engage_o
);
    cc_mode_t mode_q, mode_d;

    // Engage qualifier: idle, enabled, no brake, speed in window.
    always_comb engage_o = (mode_q == MODE_IDLE) && enable_i && !brake_i && in_window_i;

    // Next-mode selection.
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_IDLE:     if (engage_o) mode_d = MODE_AUTO;
            MODE_AUTO:     if (brake_i) mode_d = MODE_LOCKOUT;
                           else if (pedal_i) mode_d = MODE_OVERRIDE;
            MODE_OVERRIDE: if (brake_i) mode_d = MODE_LOCKOUT;
                           else if (!pedal_i) mode_d = MODE_AUTO;
            MODE_LOCKOUT:  if (!brake_i) mode_d = MODE_IDLE;
            default:       mode_d = MODE_IDLE;
        endcase
    end

    // Mode register with synchronous clear to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_IDLE;
        else        mode_q <= mode_d;
    end

    assign mode_o = mode_q;
endmodule

// File: rtl/cruise_ctrl_top.sv
// Module: cruise_ctrl_top
// Adaptive cruise mode controller: mode FSM, target capture, speed
// comparison and output decode. accel/decel depend on live speed.
// Assumes: speed_i is unsigned and synchronous to clk.
module cruise_ctrl_top
    import cc_pkg::*;
#(
    parameter int SPD_W   = cc_pkg::SPEED_W,
    parameter int ENG_MAX = cc_pkg::ENGAGE_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             brake_i,
    input  logic             pedal_i,
    input  logic [SPD_W-1:0] speed_i,
    output logic             cruise_on_o,
    output logic             accel_o,
    output logic             decel_o
);
    cc_mode_t         mode_q;
    logic             engage;
    logic             in_window;
    logic             below;
    logic             above;
    logic [SPD_W-1:0] target_q;

    cc_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (enable_i),
        .brake_i     (brake_i),
        .pedal_i     (pedal_i),
        .in_window_i (in_window),
        .mode_o      (mode_q),
        .engage_o    (engage)
    );

    cc_setpoint_reg #(.SPEED_W(SPD_W)) u_target (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (engage),
        .speed_i  (speed_i),
        .target_o (target_q)
    );

    cc_speed_cmp #(.SPEED_W(SPD_W), .ENGAGE_MAX(ENG_MAX)) u_cmp (
        .speed_i     (speed_i),
        .target_i    (target_q),
        .below_o     (below),
        .above_o     (above),
        .in_window_o (in_window)
    );

    // Output decode from mode and comparator.
    always_comb begin
        cruise_on_o = (mode_q == MODE_AUTO) || (mode_q == MODE_OVERRIDE);
        accel_o     = (mode_q == MODE_AUTO) && below;
        decel_o     = (mode_q == MODE_AUTO) && above;
    end
endmodule

// File: rtl/cruise_ctrl_checker.sv
// Module: cruise_ctrl_checker
// Temporal checks on the cruise controller, bound to the top module.
// Assumes: the mode encoding from cc_pkg.
module cruise_ctrl_checker
    import cc_pkg::*;
#(
    parameter int SPD_W   = 6,
    parameter int ENG_MAX = 50
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable_i,
    input logic             brake_i,
    input logic             pedal_i,
    input logic [SPD_W-1:0] speed_i,
    input logic             cruise_on_o,
    input logic             accel_o,
    input logic             decel_o,
    input cc_mode_t         mode_q
);
    localparam logic [SPD_W-1:0] LIMIT = SPD_W'(ENG_MAX);

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (mode_q == MODE_IDLE && !cruise_on_o));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_IDLE && (!enable_i || brake_i)) |=> mode_q == MODE_IDLE);

    assert_engage_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_IDLE && speed_i > LIMIT) |=> mode_q == MODE_IDLE);

    assert_cmd_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(accel_o && decel_o));

    assert_to_override_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_AUTO && pedal_i && !brake_i) |=> mode_q == MODE_OVERRIDE);

    assert_to_auto_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_OVERRIDE && !pedal_i && !brake_i) |=> mode_q == MODE_AUTO);

    assert_brake_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == MODE_AUTO || mode_q == MODE_OVERRIDE) && brake_i) |=> mode_q == MODE_LOCKOUT);

    assert_lockout_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == MODE_LOCKOUT |=> (mode_q == MODE_LOCKOUT || mode_q == MODE_IDLE));

    assert_no_cmd_outside_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q != MODE_AUTO |-> (!accel_o && !decel_o));
endmodule

bind cruise_ctrl_top cruise_ctrl_checker #(.SPD_W(SPD_W), .ENG_MAX(ENG_MAX)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable_i    (enable_i),
    .brake_i     (brake_i),
    .pedal_i     (pedal_i),
    .speed_i     (speed_i),
    .cruise_on_o (cruise_on_o),
    .accel_o     (accel_o),
    .decel_o     (decel_o),
    .mode_q      (mode_q)
);

// File: tb/test_cruise_ctrl_top.sv
`timescale 1ns/1ps
module test_cruise_ctrl_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable_i = 1'b0;
    logic       brake_i = 1'b0;
    logic       pedal_i = 1'b0;
    logic [5:0] speed_i = '0;
    logic       cruise_on_o, accel_o, decel_o;
    int         n_tests = 0;
    int         n_fail = 0;

    always #2.5 clk = ~clk;

    cruise_ctrl_top i_cruise_ctrl_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (enable_i),
        .brake_i     (brake_i),
        .pedal_i     (pedal_i),
        .speed_i     (speed_i),
        .cruise_on_o (cruise_on_o),
        .accel_o     (accel_o),
        .decel_o     (decel_o)
    );

    // Advance one edge; sample one time unit later.
    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Compare {cruise, accel, decel} with the expected pattern.
    task automatic check(input string req, input logic [2:0] exp);
        logic [2:0] act;
        act = {cruise_on_o, accel_o, decel_o};
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(input logic en, input logic br, input logic pd, input logic [5:0] sp);
        enable_i = en; brake_i = br; pedal_i = pd; speed_i = sp;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        drive(1, 0, 0, 6'd20);
        step(3);
        check("R1 reset outputs", 3'b000);
        rst_n = 1'b1;
        drive(0, 0, 0, 6'd20);
        step();
        check("R2 idle without enable", 3'b000);
    endtask

    task automatic t_engage_block;
        drive(1, 1, 0, 6'd30);
        step();
        check("R2 brake blocks engage", 3'b000);
        drive(1, 0, 0, 6'd51);
        step();
        check("R3 speed 51 blocks engage", 3'b000);
        drive(1, 0, 0, 6'd63);
        step();
        check("R3 speed 63 blocks engage", 3'b000);
    endtask

    task automatic t_engage_auto;
        drive(1, 0, 0, 6'd50);
        step();
        check("R3 engage at 50, equal speed", 3'b100);
        speed_i = 6'd40;
        #1;
        check("R5 below target accel", 3'b110);
        speed_i = 6'd60;
        #1;
        check("R5 above target decel", 3'b101);
        drive(0, 0, 0, 6'd45);
        step(2);
        check("R4 target kept at 50", 3'b110);
    endtask

    task automatic t_override;
        drive(0, 0, 1, 6'd40);
        step();
        check("R6 override mode outputs", 3'b100);
        step();
        check("R6 override holds", 3'b100);
        pedal_i = 1'b0;
        step();
        check("R7 back to auto", 3'b110);
    endtask

    task automatic t_brake_from_auto;
        drive(1, 1, 1, 6'd40);
        step();
        check("R8 brake beats pedal", 3'b000);
        step(3);
        check("R9 lockout holds", 3'b000);
        drive(1, 0, 0, 6'd20);
        step();
        check("R9 lockout exits to idle", 3'b000);
        step();
        check("R2 re-engage from idle", 3'b100);
        speed_i = 6'd25;
        #1;
        check("R4 new target 20 captured", 3'b101);
    endtask

    task automatic t_brake_from_override;
        drive(0, 0, 1, 6'd25);
        step();
        check("R10 cruise on in override", 3'b100);
        brake_i = 1'b1;
        step();
        check("R8 override to lockout", 3'b000);
        drive(0, 0, 0, 6'd10);
        step();
        check("R10 idle outputs", 3'b000);
        step();
        check("R2 idle stays without enable", 3'b000);
    endtask

    task automatic t_reset_mid;
        drive(1, 0, 0, 6'd30);
        step();
        check("R2 engage before reset", 3'b100);
        rst_n = 1'b0;
        step();
        check("R1 reset from auto", 3'b000);
        rst_n = 1'b1;
        drive(0, 0, 0, 6'd30);
        step();
        check("R1 idle after reset", 3'b000);
    endtask

    initial begin
        t_reset();
        t_engage_block();
        t_engage_auto();
        t_override();
        t_brake_from_auto();
        t_brake_from_override();
        t_reset_mid();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run incomplete, actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule